// File: doc/BRIEF.md
# Speculative Store Memory with Undo Log

This block is a small byte-addressed data memory for an out-of-order core. It carries out reads and writes of 1, 2 or 4 bytes in a single cycle. A write may come from an instruction that has not yet retired. Each write therefore also records the bytes it changed in an undo log. The log entry is keyed by the writer's reorder-buffer tag and holds, for each changed byte, its address, its previous value and the cycle stamp of the write.

When the instruction behind a tag retires, a commit pulse for that tag drops its log entry from the set to undo. A flush pulse starts a rollback sequencer. The sequencer writes back one logged byte per cycle, always taking the newest unretired write first. As a result, each location ends holding the value it had before the oldest unretired write to it. The status output reads busy until the rollback is done, and requests and commits seen while busy are dropped.

Multi-byte accesses are little-endian. Byte k of an access sits at address (addr + k) modulo the memory size. Reads are zero-extended to 32 bits.

Top module: `spec_store_mem`

## Requirements
- R1: After reset every memory byte is zero, `stat_o` is 1 (free), and `rd_data_o` and `done_tag_o` are zero.
- R2: `req_kind_i[1:0]` selects the operation: 00 none, 01 read, 10 write, 11 invalid. `req_kind_i[3:2]` selects the size: 0 is 1 byte, 1 is 2 bytes, 2 is 4 bytes, 3 is invalid. An invalid operation, or a read or write with size 3, leaves memory and the log untouched, and `stat_o` is 1 on the next cycle.
- R3: A read accepted while free gives `stat_o` = 2 on the next cycle. At the same time `rd_data_o` holds byte k from address addr+k in bits [8k+7:8k], with the bits above the access size at zero, and `done_tag_o` holds the request tag.
- R4: A write accepted while free stores byte k of `req_wdata_i` at address addr+k, wrapping modulo the memory size, and leaves all other bytes unchanged. On the next cycle `stat_o` is 1 and `done_tag_o` holds the request tag.
- R5: A write replaces the whole log entry of its tag. A second write under a tag that has not retired discards the first write's undo record.
- R6: A commit pulse accepted while free retires the log entry of `commit_tag_i`. Bytes written under that tag keep their values through a later flush, unless a newer unretired write covered them.
- R7: A flush restores every logged byte of every unretired entry, newest write first. Each location ends holding the value it had before the oldest unretired write to it.
- R8: After a flush, `stat_o` reads 0 for exactly max(N,1) cycles, where N is the number of logged bytes in unretired entries. Requests and commits presented during those cycles have no effect, and `rd_data_o` holds its value.
- R9: A completed rollback empties the log, so a flush that follows at once keeps the block busy for exactly one cycle and changes no byte.
- R10: An operation of 00 while free gives `stat_o` = 1 and leaves `rd_data_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flush_i | input | 1 | Start rollback of all unretired writes |
| commit_i | input | 1 | Retire the log entry of `commit_tag_i` |
| commit_tag_i | input | IW | Tag being retired |
| req_kind_i | input | 4 | [1:0] operation, [3:2] size code |
| req_addr_i | input | MEM_AW | Byte address of the access |
| req_wdata_i | input | 32 | Write data, little-endian |
| req_tag_i | input | IW | Reorder-buffer tag of the requester |
| stat_o | output | 2 | 0 busy, 1 free, 2 free with read data valid |
| rd_data_o | output | 32 | Zero-extended read result |
| done_tag_o | output | IW | Tag of the last completed access |

## Verification
The bench covers four hazards.

The first is overlapping unretired writes to the same bytes. If the rollback runs oldest-first, a location is left with a value written by a speculative store instead of the value it had before.

The second is writes that wrap past the top address. A wrong address increment would corrupt low memory, or log the wrong old byte.

The third is a retired entry mixed with newer unretired ones. Dropping the retire would roll back committed data, and ignoring the newer entry would leave speculative bytes in memory.

The fourth is the busy window. The bench counts its exact length against the number of logged bytes, and presents writes and commits during it. A design that accepted them would show altered memory afterwards, or a rollback whose length is off.

// File: rtl/ssu_pkg.sv
`timescale 1ns/1ps
package ssu_pkg;
   localparam int LANES  = 4;
   localparam int WORD_W = 8 * LANES;

   typedef enum logic [1:0] {
      OP_NONE  = 2'b00,
      OP_READ  = 2'b01,
      OP_WRITE = 2'b10,
      OP_BAD   = 2'b11
   } op_e;

   typedef enum logic [1:0] {
      ST_BUSY = 2'd0,
      ST_FREE = 2'd1,
      ST_DATA = 2'd2
   } stat_e;

   // Byte-lane enable for a size code; an empty mask marks an illegal size.
   function automatic logic [LANES-1:0] size_mask(input logic [1:0] code);
      case (code)
         2'd0:    return 4'b0001;
         2'd1:    return 4'b0011;
         2'd2:    return 4'b1111;
         default: return 4'b0000;
      endcase
   endfunction
endpackage

// File: rtl/ssu_byte_mem.sv
`timescale 1ns/1ps
module ssu_byte_mem
   import ssu_pkg::*;
#(
   parameter int AW = 8
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [LANES-1:0]           we,
   input  logic [LANES-1:0][AW-1:0]   wa,
   input  logic [LANES-1:0][7:0]      wd,
   input  logic [LANES-1:0][AW-1:0]   ra,
   output logic [LANES-1:0][7:0]      rd
);
   localparam int DEPTH = 1 << AW;

   logic [7:0] mem [DEPTH];

   // Lane addresses of one access are distinct, so lanes never collide.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= 8'h00;
      end else begin
         for (int l = 0; l < LANES; l++) begin
            if (we[l]) mem[wa[l]] <= wd[l];
         end
      end
   end

   for (genvar l = 0; l < LANES; l++) begin : g_rd
      assign rd[l] = mem[ra[l]];
   end
endmodule

// File: rtl/ssu_newest_pick.sv
`timescale 1ns/1ps
module ssu_newest_pick #(
   parameter int N   = 32,
   parameter int TSW = 32,
   localparam int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]          valid,
   input  logic [N-1:0][TSW-1:0] stamp,
   output logic                  found,
   output logic [IW-1:0]         idx
);
   logic [TSW-1:0] best;

   // Linear scan; stamps of live entries are unique, so ties cannot arise.
   always_comb begin
      found = 1'b0;
      idx   = '0;
      best  = '0;
      for (int i = 0; i < N; i++) begin
         if (valid[i] && (!found || stamp[i] > best)) begin
            found = 1'b1;
            idx   = IW'(i);
            best  = stamp[i];
         end
      end
   end
endmodule

// File: rtl/ssu_undo_log.sv
`timescale 1ns/1ps
module ssu_undo_log
   import ssu_pkg::*;
#(
   parameter int TAGS = 32,
   parameter int AW   = 8,
   parameter int TSW  = 32,
   localparam int IW  = $clog2(TAGS)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     log_we,
   input  logic [IW-1:0]            log_tag,
   input  logic [TSW-1:0]           log_ts,
   input  logic [LANES-1:0]         log_mask,
   input  logic [LANES-1:0][AW-1:0] log_addr,
   input  logic [LANES-1:0][7:0]    log_old,
   input  logic                     commit_en,
   input  logic [IW-1:0]            commit_tag,
   input  logic                     pop_en,
   output logic                     any_pend,
   output logic                     pop_valid,
   output logic [AW-1:0]            pop_addr,
   output logic [7:0]               pop_old,
   output logic                     pop_last
);
   logic [TAGS-1:0]                      pend;
   logic [TAGS-1:0][TSW-1:0]             ts_q;
   logic [TAGS-1:0][LANES-1:0]           chg;
   logic [TAGS-1:0][LANES-1:0][AW-1:0]   addr_q;
   logic [TAGS-1:0][LANES-1:0][7:0]      old_q;

   logic                 sel_found;
   logic [IW-1:0]        sel;
   logic [$clog2(LANES)-1:0] slot;
   logic                 slot_found;
   logic                 entry_last;
   logic [TAGS-1:0]      others;

   ssu_newest_pick #(.N(TAGS), .TSW(TSW)) u_pick (
      .valid (pend),
      .stamp (ts_q),
      .found (sel_found),
      .idx   (sel)
   );

   always_comb begin
      slot       = '0;
      slot_found = 1'b0;
      for (int l = LANES - 1; l >= 0; l--) begin
         if (chg[sel][l]) begin
            slot       = ($clog2(LANES))'(l);
            slot_found = 1'b1;
         end
      end
   end

   assign entry_last = ($countones(chg[sel]) <= 1);
   assign others     = pend & ~(TAGS'(1) << sel);
   assign any_pend   = |pend;
   assign pop_valid  = sel_found & slot_found;
   assign pop_addr   = addr_q[sel][slot];
   assign pop_old    = old_q[sel][slot];
   assign pop_last   = sel_found & entry_last & ~(|others);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend   <= '0;
         ts_q   <= '0;
         chg    <= '0;
         addr_q <= '0;
         old_q  <= '0;
      end else begin
         if (pop_en && sel_found) begin
            if (slot_found) chg[sel][slot] <= 1'b0;
            if (entry_last) pend[sel] <= 1'b0;
         end
         if (commit_en) pend[commit_tag] <= 1'b0;
         if (log_we) begin
            pend[log_tag]   <= 1'b1;
            ts_q[log_tag]   <= log_ts;
            chg[log_tag]    <= log_mask;
            addr_q[log_tag] <= log_addr;
            old_q[log_tag]  <= log_old;
         end
      end
   end
endmodule

// File: rtl/spec_store_mem.sv
`timescale 1ns/1ps
module spec_store_mem
   import ssu_pkg::*;
#(
   parameter int MEM_AW = 8,
   parameter int TAGS   = 32,
   parameter int TSW    = 32,
   localparam int IW    = $clog2(TAGS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush_i,
   input  logic              commit_i,
   input  logic [IW-1:0]     commit_tag_i,
   input  logic [3:0]        req_kind_i,
   input  logic [MEM_AW-1:0] req_addr_i,
   input  logic [31:0]       req_wdata_i,
   input  logic [IW-1:0]     req_tag_i,
   output logic [1:0]        stat_o,
   output logic [31:0]       rd_data_o,
   output logic [IW-1:0]     done_tag_o
);
   if (MEM_AW < 2 || MEM_AW > 16) begin : g_bad_aw
      $error("MEM_AW must lie in 2..16");
   end
   if (TAGS < 2 || (1 << IW) != TAGS) begin : g_bad_tags
      $error("TAGS must be a power of two, at least 2");
   end
   if (TSW < 8) begin : g_bad_tsw
      $error("TSW must be at least 8");
   end

   typedef enum logic {M_RUN, M_UNDO} mode_e;

   mode_e                         mode_q;
   stat_e                         stat_q;
   logic [TSW-1:0]                ts_q;
   logic [31:0]                   rdata_q;
   logic [IW-1:0]                 tag_q;

   op_e                           op;
   logic [LANES-1:0]              sz_mask;
   logic                          run, acc_rd, acc_wr, commit_en;
   logic [LANES-1:0][MEM_AW-1:0]  lane_addr, wr_addr;
   logic [LANES-1:0][7:0]         lane_rd, wr_byte;
   logic [LANES-1:0]              wr_en;
   logic [31:0]                   rd_word;

   logic                          any_pend, pop_valid, pop_last, pop_do;
   logic [MEM_AW-1:0]             pop_addr;
   logic [7:0]                    pop_old;

   assign op        = op_e'(req_kind_i[1:0]);
   assign sz_mask   = size_mask(req_kind_i[3:2]);
   assign run       = (mode_q == M_RUN);
   assign acc_rd    = run & ~flush_i & (op == OP_READ)  & (|sz_mask);
   assign acc_wr    = run & ~flush_i & (op == OP_WRITE) & (|sz_mask);
   assign commit_en = run & ~flush_i & commit_i;
   assign pop_do    = ~run & pop_valid;

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      assign lane_addr[l]      = req_addr_i + MEM_AW'(l);
      assign rd_word[8*l +: 8] = sz_mask[l] ? lane_rd[l] : 8'h00;
      if (l == 0) begin : g_restore_port
         assign wr_en[l]   = (acc_wr & sz_mask[l]) | pop_do;
         assign wr_addr[l] = run ? lane_addr[l] : pop_addr;
         assign wr_byte[l] = run ? req_wdata_i[8*l +: 8] : pop_old;
      end else begin : g_store_port
         assign wr_en[l]   = acc_wr & sz_mask[l];
         assign wr_addr[l] = lane_addr[l];
         assign wr_byte[l] = req_wdata_i[8*l +: 8];
      end
   end

   ssu_byte_mem #(.AW(MEM_AW)) u_mem (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (wr_en),
      .wa    (wr_addr),
      .wd    (wr_byte),
      .ra    (lane_addr),
      .rd    (lane_rd)
   );

   ssu_undo_log #(.TAGS(TAGS), .AW(MEM_AW), .TSW(TSW)) u_log (
      .clk        (clk),
      .rst_n      (rst_n),
      .log_we     (acc_wr),
      .log_tag    (req_tag_i),
      .log_ts     (ts_q),
      .log_mask   (sz_mask),
      .log_addr   (lane_addr),
      .log_old    (lane_rd),
      .commit_en  (commit_en),
      .commit_tag (commit_tag_i),
      .pop_en     (~run),
      .any_pend   (any_pend),
      .pop_valid  (pop_valid),
      .pop_addr   (pop_addr),
      .pop_old    (pop_old),
      .pop_last   (pop_last)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q  <= M_RUN;
         stat_q  <= ST_FREE;
         ts_q    <= '0;
         rdata_q <= '0;
         tag_q   <= '0;
      end else begin
         ts_q <= flush_i ? '0 : ts_q + TSW'(1);
         if (run) begin
            if (flush_i) begin
               mode_q <= M_UNDO;
               stat_q <= ST_BUSY;
            end else if (acc_rd) begin
               stat_q  <= ST_DATA;
               rdata_q <= rd_word;
               tag_q   <= req_tag_i;
            end else if (acc_wr) begin
               stat_q <= ST_FREE;
               tag_q  <= req_tag_i;
            end else begin
               stat_q <= ST_FREE;
            end
         end else if (pop_last || !any_pend) begin
            mode_q <= M_RUN;
            stat_q <= ST_FREE;
         end else begin
            stat_q <= ST_BUSY;
         end
      end
   end

   assign stat_o     = stat_q;
   assign rd_data_o  = rdata_q;
   assign done_tag_o = tag_q;
endmodule

// File: rtl/ssu_checks.sv
`timescale 1ns/1ps
module ssu_checks (
   input logic        clk,
   input logic        rst_n,
   input logic        flush_i,
   input logic [3:0]  req_kind_i,
   input logic [1:0]  stat_o,
   input logic [31:0] rd_data_o
);
   logic free, rd_req, wr_req, bad_req, none_req;
   assign free     = (stat_o != 2'd0) && !flush_i;
   assign rd_req   = (req_kind_i[1:0] == 2'b01) && (req_kind_i[3:2] != 2'b11);
   assign wr_req   = (req_kind_i[1:0] == 2'b10) && (req_kind_i[3:2] != 2'b11);
   assign bad_req  = (req_kind_i[1:0] == 2'b11) ||
                     ((req_kind_i[1:0] != 2'b00) && (req_kind_i[3:2] == 2'b11));
   assign none_req = (req_kind_i[1:0] == 2'b00);

   assert_stat_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
      stat_o != 2'd3);

   assert_bad_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (free && bad_req) |=> (stat_o == 2'd1));

   assert_read_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (free && rd_req) |=> (stat_o == 2'd2));

   assert_write_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (free && wr_req) |=> (stat_o == 2'd1));

   assert_flush_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ((stat_o != 2'd0) && flush_i) |=> (stat_o == 2'd0));

   assert_busy_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_o == 2'd0) |=> $stable(rd_data_o));

   assert_none_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (free && none_req) |=> ((stat_o == 2'd1) && $stable(rd_data_o)));
endmodule

bind spec_store_mem ssu_checks u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .flush_i    (flush_i),
   .req_kind_i (req_kind_i),
   .stat_o     (stat_o),
   .rd_data_o  (rd_data_o)
);

// File: tb/sim_spec_store_mem.sv
`timescale 1ns/1ps
module sim_spec_store_mem;
   localparam int AW    = 8;
   localparam int TAGS  = 32;
   localparam int IW    = 5;
   localparam int DEPTH = 1 << AW;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          flush_i, commit_i;
   logic [IW-1:0] commit_tag_i, req_tag_i, done_tag_o;
   logic [3:0]    req_kind_i;
   logic [AW-1:0] req_addr_i;
   logic [31:0]   req_wdata_i, rd_data_o;
   logic [1:0]    stat_o;

   int checks = 0;
   int errors = 0;

   logic [7:0]    mm [DEPTH];
   bit            lv [TAGS];
   int            lseq [TAGS];
   int            ln [TAGS];
   logic [AW-1:0] la [TAGS][4];
   logic [7:0]    lo [TAGS][4];
   int            seqc = 0;

   always #4 clk = ~clk;

   spec_store_mem #(.MEM_AW(AW), .TAGS(TAGS), .TSW(32)) u0 (
      .clk(clk), .rst_n(rst_n), .flush_i(flush_i), .commit_i(commit_i),
      .commit_tag_i(commit_tag_i), .req_kind_i(req_kind_i), .req_addr_i(req_addr_i),
      .req_wdata_i(req_wdata_i), .req_tag_i(req_tag_i), .stat_o(stat_o),
      .rd_data_o(rd_data_o), .done_tag_o(done_tag_o)
   );

   task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", r, act, exp);
      end
   endtask

   task automatic idle_in();
      flush_i = 0; commit_i = 0; commit_tag_i = '0;
      req_kind_i = 4'h0; req_addr_i = '0; req_wdata_i = '0; req_tag_i = '0;
   endtask

   function automatic logic [31:0] mexp(input logic [1:0] sz, input logic [AW-1:0] a);
      logic [31:0] r = '0;
      for (int k = 0; k < (1 << sz); k++) r[8*k +: 8] = mm[a + AW'(k)];
      return r;
   endfunction

   task automatic req(input logic [1:0] op, input logic [1:0] sz, input logic [AW-1:0] a,
                      input logic [31:0] d, input logic [IW-1:0] tag);
      @(negedge clk);
      req_kind_i = {sz, op}; req_addr_i = a; req_wdata_i = d; req_tag_i = tag;
      @(negedge clk);
      idle_in();
   endtask

   task automatic mwrite(input logic [1:0] sz, input logic [AW-1:0] a, input logic [31:0] d,
                         input logic [IW-1:0] tag);
      lv[tag] = 1; lseq[tag] = seqc++; ln[tag] = 1 << sz;
      for (int k = 0; k < (1 << sz); k++) begin
         la[tag][k] = a + AW'(k);
         lo[tag][k] = mm[a + AW'(k)];
         mm[a + AW'(k)] = d[8*k +: 8];
      end
      req(2'b10, sz, a, d, tag);
      chk("R4 write status", {30'd0, stat_o}, 32'd1);
      chk("R4 write done tag", {27'd0, done_tag_o}, {27'd0, tag});
   endtask

   task automatic mread(input logic [1:0] sz, input logic [AW-1:0] a, input logic [IW-1:0] tag,
                        input string r);
      logic [31:0] e = mexp(sz, a);
      req(2'b01, sz, a, 32'h0, tag);
      chk({r, " R3 status"}, {30'd0, stat_o}, 32'd2);
      chk({r, " R3 data"}, rd_data_o, e);
      chk({r, " R3 tag"}, {27'd0, done_tag_o}, {27'd0, tag});
   endtask

   task automatic mcommit(input logic [IW-1:0] tag);
      @(negedge clk);
      commit_i = 1; commit_tag_i = tag;
      @(negedge clk);
      idle_in();
      lv[tag] = 0;
   endtask

   task automatic mflush(input bit poke);
      int n = 0;
      int busy = 0;
      int best, bi;
      for (int t = 0; t < TAGS; t++) if (lv[t]) n += ln[t];
      @(negedge clk);
      flush_i = 1;
      @(negedge clk);
      flush_i = 0;
      while (stat_o == 2'd0 && busy < 2000) begin
         busy++;
         if (poke) begin
            req_kind_i = 4'b1010; req_addr_i = 8'h80; req_wdata_i = 32'hEEEEEEEE;
            req_tag_i = 5'd3; commit_i = 1; commit_tag_i = IW'(busy);
         end
         @(negedge clk);
      end
      idle_in();
      chk("R8 busy cycles after flush", busy, (n == 0) ? 1 : n);
      // Model rollback: newest sequence number first.
      do begin
         best = -1; bi = 0;
         for (int t = 0; t < TAGS; t++)
            if (lv[t] && lseq[t] > best) begin best = lseq[t]; bi = t; end
         if (best >= 0) begin
            for (int k = 0; k < ln[bi]; k++) mm[la[bi][k]] = lo[bi][k];
            lv[bi] = 0;
         end
      end while (best >= 0);
   endtask

   task automatic verify_all(input string r);
      for (int w = 0; w < DEPTH / 4; w++) mread(2'd2, AW'(4 * w), 5'd0, r);
   endtask

   initial begin
      #(8 * 150000);
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      for (int i = 0; i < DEPTH; i++) mm[i] = 8'h00;
      for (int t = 0; t < TAGS; t++) lv[t] = 0;
      idle_in();
      rst_n = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      chk("R1 reset status", {30'd0, stat_o}, 32'd1);
      chk("R1 reset read data", rd_data_o, 32'd0);
      chk("R1 reset done tag", {27'd0, done_tag_o}, 32'd0);
      verify_all("R1 memory zero");

      // Overlapping unretired writes: newest-first rollback gives zeros.
      mwrite(2'd2, 8'h10, 32'h11223344, 5'd1);
      mwrite(2'd1, 8'h12, 32'h0000AABB, 5'd2);
      mwrite(2'd0, 8'h10, 32'h000000CC, 5'd3);
      mread(2'd2, 8'h10, 5'd9, "R4 overlap");
      mflush(0);
      mread(2'd2, 8'h10, 5'd9, "R7 newest first");
      chk("R7 literal zero", rd_data_o, 32'h0);

      // Retired entry survives; newer unretired byte is undone.
      mwrite(2'd2, 8'h20, 32'hDEADBEEF, 5'd4);
      mcommit(5'd4);
      mwrite(2'd0, 8'h21, 32'h00000055, 5'd5);
      mflush(1);
      mread(2'd2, 8'h20, 5'd4, "R6 retired kept");
      chk("R6 literal", rd_data_o, 32'hDEADBEEF);
      mread(2'd2, 8'h80, 5'd0, "R8 write while busy ignored");

      mflush(0);
      mread(2'd2, 8'h20, 5'd4, "R9 empty log after rollback");

      // Same tag reused before retire.
      mwrite(2'd0, 8'h40, 32'h000000AA, 5'd6);
      mwrite(2'd0, 8'h41, 32'h000000BB, 5'd6);
      mflush(0);
      mread(2'd1, 8'h40, 5'd6, "R5 entry replaced");
      chk("R5 literal", rd_data_o, 32'h000000AA);

      // Illegal requests.
      req(2'b11, 2'd2, 8'h50, 32'hFFFFFFFF, 5'd1);
      chk("R2 invalid op status", {30'd0, stat_o}, 32'd1);
      req(2'b10, 2'd3, 8'h50, 32'hFFFFFFFF, 5'd1);
      chk("R2 invalid size status", {30'd0, stat_o}, 32'd1);
      mread(2'd2, 8'h50, 5'd1, "R2 no store");
      mflush(0);

      // No-op holds data; zero-extension.
      mread(2'd2, 8'h20, 5'd2, "R10 setup");
      req(2'b00, 2'd0, 8'h00, 32'h0, 5'd0);
      chk("R10 none status", {30'd0, stat_o}, 32'd1);
      chk("R10 data held", rd_data_o, 32'hDEADBEEF);
      mread(2'd0, 8'h23, 5'd2, "R3 zext byte");
      chk("R3 byte literal", rd_data_o, 32'h000000DE);
      mread(2'd1, 8'h22, 5'd2, "R3 zext half");
      chk("R3 half literal", rd_data_o, 32'h0000DEAD);

      // Wrap past top address.
      mwrite(2'd2, 8'hFE, 32'h01020304, 5'd9);
      mread(2'd2, 8'hFE, 5'd9, "R4 wrap");
      mread(2'd0, 8'h00, 5'd9, "R4 wrap low byte");
      chk("R4 wrap literal", rd_data_o, 32'h00000002);
      mcommit(5'd9);

      // Sweep every size and address, with some entries retired.
      for (int sz = 0; sz < 3; sz++) begin
         for (int a = 0; a < DEPTH; a++) begin
            logic [31:0] d = {8'(a) ^ 8'h5A, 8'(a + 17), ~8'(a), 8'(a) + 8'(sz)};
            mwrite(2'(sz), AW'(a), d, IW'(a % TAGS));
            mread(2'(sz), AW'(a), IW'(a % TAGS), "R4 sweep readback");
            if (a % 3 == 0) mcommit(IW'(a % TAGS));
         end
         mflush(sz == 1);
         verify_all("R7 sweep rollback");
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule